// File: doc/BRIEF.md
# Shared-Medium Transmit Access Controller

This block decides when a station attached to a shared, contended medium may put a frame on the wire, and what happens after two stations talk at once. A frame source raises a request level together with the frame's byte count. The block waits for the carrier-sense input to show a quiet line, then raises its transmit enable. It streams the frame out one byte per eight bit-time ticks and appends zero bytes until the frame reaches the minimum length. Because of that minimum, any other station's collision is seen while this station is still transmitting.

If the collision input rises while frame bytes are going out, the block stops sending frame data at once. It signals the collision with a jam interval and then stays silent for a random number of slot times before it tries the same frame again. The random range doubles with each collision up to a cap. A successful frame ends with a one-cycle done pulse. A frame that collides on every one of the permitted attempts is dropped with a one-cycle error pulse. Bytes come in over a ready-strobed stream. The source keeps its data valid and rewinds to byte 0 whenever the jam output goes high. Line coding, preamble, checksum and reception are handled elsewhere.

Top module: `csma_tx_ctrl`

## Requirements
- R1: A pending frame starts only on a clock edge at which `carrier` is low. `tx_en` goes high the cycle after that edge and stays low for as long as `carrier` stays high.
- R2: Each byte lasts 8 `bit_tick` pulses. While byte index i < `frm_len` is being sent, `tx_data` equals `in_data`. `in_ready` is high, combinationally, exactly in the cycle of that byte's eighth tick when no collision is present.
- R3: A frame is MIN_BYTES (64) bytes long when `frm_len` is smaller. The padding bytes drive `tx_data` to 0x00 and never raise `in_ready`.
- R4: `done` pulses for one cycle right after the edge that takes the eighth tick of the last byte. `tx_en` is low in that same cycle.
- R5: When `collision` is high at a clock edge while frame bytes are being sent, the next cycle shows `jam` = 1 with `tx_en` still 1 and `tx_data` = 0x00.
- R6: `jam` stays high for exactly JAM_BITS (32) `bit_tick` pulses and is never high without `tx_en`.
- R7: After the n-th collision of a frame, the line stays quiet for k·SLOT_BITS ticks, where 0 ≤ k ≤ 2^min(n,BACKOFF_LIMIT) − 1 and k is drawn from an LFSR. Transmission then restarts at byte 0.
- R8: When the MAX_ATTEMPTS-th (16th) collision of a frame ends its jam, `excess_err` pulses for one cycle, no retry follows, and the block accepts a new request.
- R9: `collision` has no effect when no frame bytes are being sent, whether the block is idle, waiting or jamming.
- R10: During and right after reset, `tx_en`, `jam`, `in_ready`, `done`, `excess_err` and `tx_data` are all 0.
- R11: Each new request starts its attempt count at zero. A frame that follows one dropped for excess collisions uses the range 0..1 after its first collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One pulse per bit time on the medium |
| frm_req | input | 1 | Frame pending; held until `done` or `excess_err` |
| frm_len | input | LEN_W | Frame byte count, taken when the request is accepted |
| carrier | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Current source byte consumed |
| tx_en | output | 1 | Station driving the medium (frame or jam) |
| tx_data | output | 8 | Byte currently sent (0x00 for padding and jam) |
| jam | output | 1 | Collision jam interval |
| done | output | 1 | One-cycle pulse: frame sent |
| excess_err | output | 1 | One-cycle pulse: frame dropped after too many collisions |

## Verification
A wrong state register shows at the ports within one cycle: `tx_en` and `jam` decode the state directly. A bad byte or bit counter shifts an `in_ready` strobe or a padding byte within eight ticks, and moves the `done` pulse. A wrong attempt count or backoff mask can be seen only at the next retry, where the quiet interval must be a whole number of slots inside the allowed range. A wrong limit shows up only when the dropped-frame pulse arrives or fails to arrive. The bench therefore runs a frame through every collision allowed and then one more frame after it.

// File: rtl/csma_pkg.sv
// Shared types for the transmit access controller.
package csma_pkg;

    // Controller phases; SEND and JAM both drive the medium.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_SEND    = 3'd2,
        ST_JAM     = 3'd3,
        ST_BACKOFF = 3'd4
    } tx_state_t;

endpackage

// File: rtl/csma_lfsr.sv
// Free-running Galois LFSR that supplies the random backoff draw.
// It advances every clock, and the whole state is XOR-folded into OUT_W bits.
// Assumes TAPS is a maximal polynomial and SEED is non-zero.
module csma_lfsr #(
    parameter int unsigned W     = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter int unsigned OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);

    logic [W-1:0] state_q;

    // Shift once per clock, feeding the taps back when bit 0 is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
        end
    end

    // Fold every state bit into the narrower random value.
    always_comb begin
        rnd = '0;
        for (int j = 0; j < int'(W); j++) begin
            rnd[j % int'(OUT_W)] = rnd[j % int'(OUT_W)] ^ state_q[j];
        end
    end

endmodule

// File: rtl/csma_backoff.sv
// Counts down a loaded number of slot times, one slot being SLOT_BITS
// bit ticks. expire is high in the cycle of the last tick of the last slot.
// Assumes load is never raised with a zero slot count.
module csma_backoff #(
    parameter int unsigned SLOT_BITS = 512,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_slots,
    output logic             expire
);

    localparam int unsigned SLOT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    logic [CNT_W-1:0]  slots_q;
    logic [SLOT_W-1:0] bit_q;
    logic              slot_end;

    assign slot_end = bit_tick && (bit_q == SLOT_W'(SLOT_BITS - 1));
    assign expire   = (slots_q == CNT_W'(1)) && slot_end;

    // Load a new wait, or count bit ticks within the running slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            bit_q   <= '0;
        end else if (load) begin
            slots_q <= load_slots;
            bit_q   <= '0;
        end else if (slots_q != '0 && bit_tick) begin
            if (slot_end) begin
                bit_q   <= '0;
                slots_q <= slots_q - CNT_W'(1);
            end else begin
                bit_q <= bit_q + SLOT_W'(1);
            end
        end
    end

endmodule

// File: rtl/csma_frame_counter.sv
// Tracks byte and bit position inside the frame being sent and flags
// payload versus padding bytes and the end of the padded frame.
// Assumes frames are at least one byte; shorter ones grow to MIN_BYTES.
module csma_frame_counter #(
    parameter int unsigned LEN_W     = 11,
    parameter int unsigned MIN_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             bit_tick,
    input  logic [LEN_W-1:0] frame_len,
    output logic             is_data,
    output logic             byte_end,
    output logic             last_end
);

    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_BYTES);

    logic [LEN_W-1:0] idx_q;
    logic [2:0]       bit_q;
    logic [LEN_W-1:0] total_m1;

    assign total_m1 = ((frame_len < MIN_LEN) ? MIN_LEN : frame_len) - LEN_W'(1);
    assign is_data  = idx_q < frame_len;
    assign byte_end = run && bit_tick && (bit_q == 3'd7);
    assign last_end = byte_end && (idx_q == total_m1);

    // Rewind at each attempt, then step bits and bytes on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            bit_q <= '0;
        end else if (start) begin
            idx_q <= '0;
            bit_q <= '0;
        end else if (run && bit_tick) begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
                idx_q <= idx_q + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/csma_tx_ctrl.sv
// Transmit access controller for a contended medium: defers to carrier,
// sends a zero-padded frame, jams and backs off on collision, retries
// up to MAX_ATTEMPTS times. Assumes bit_tick is a one-cycle strobe and
// the byte source rewinds to byte 0 whenever jam is high.
module csma_tx_ctrl
    import csma_pkg::*;
#(
    parameter int unsigned LEN_W         = 11,
    parameter int unsigned MIN_BYTES     = 64,
    parameter int unsigned JAM_BITS      = 32,
    parameter int unsigned SLOT_BITS     = 512,
    parameter int unsigned BACKOFF_LIMIT = 10,
    parameter int unsigned MAX_ATTEMPTS  = 16,
    parameter int unsigned LFSR_W        = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             frm_req,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             carrier,
    input  logic             collision,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             tx_en,
    output logic [7:0]       tx_data,
    output logic             jam,
    output logic             done,
    output logic             excess_err
);

    localparam int unsigned ATT_W  = $clog2(MAX_ATTEMPTS + 1);
    localparam int unsigned JAM_W  = (JAM_BITS > 1) ? $clog2(JAM_BITS) : 1;
    localparam int unsigned DRAW_W = BACKOFF_LIMIT;

    tx_state_t         state_q;
    logic [LEN_W-1:0]  len_q;
    logic [ATT_W-1:0]  attempts_q;
    logic [JAM_W-1:0]  jam_cnt_q;
    logic              done_q;
    logic              err_q;

    logic [DRAW_W-1:0] rnd;
    logic [ATT_W-1:0]  exp_sel;
    logic [DRAW_W-1:0] mask;
    logic [DRAW_W-1:0] draw;
    logic              jam_last;
    logic              limit_hit;
    logic              bo_load;
    logic              bo_expire;
    logic              fc_start;
    logic              fc_run;
    logic              byte_is_data;
    logic              byte_end;
    logic              last_byte_end;

    csma_lfsr #(
        .W     (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED),
        .OUT_W (DRAW_W)
    ) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    csma_backoff #(
        .SLOT_BITS (SLOT_BITS),
        .CNT_W     (DRAW_W)
    ) i_backoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .load       (bo_load),
        .load_slots (draw),
        .expire     (bo_expire)
    );

    csma_frame_counter #(
        .LEN_W     (LEN_W),
        .MIN_BYTES (MIN_BYTES)
    ) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fc_start),
        .run       (fc_run),
        .bit_tick  (bit_tick),
        .frame_len (len_q),
        .is_data   (byte_is_data),
        .byte_end  (byte_end),
        .last_end  (last_byte_end)
    );

    // Truncated exponential range: mask of min(attempts, limit) low ones.
    always_comb begin
        exp_sel = (attempts_q > ATT_W'(BACKOFF_LIMIT)) ? ATT_W'(BACKOFF_LIMIT) : attempts_q;
        mask    = ~({DRAW_W{1'b1}} << exp_sel);
        draw    = rnd & mask;
    end

    assign jam_last  = jam_cnt_q == JAM_W'(JAM_BITS - 1);
    assign limit_hit = attempts_q == ATT_W'(MAX_ATTEMPTS);
    assign fc_start  = (state_q == ST_WAIT) && !carrier;
    assign fc_run    = (state_q == ST_SEND) && !collision;
    assign bo_load   = (state_q == ST_JAM) && bit_tick && jam_last && !limit_hit && (draw != '0);

    // Sequence defer, send, jam and backoff; count attempts per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            len_q      <= '0;
            attempts_q <= '0;
            jam_cnt_q  <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (frm_req) begin
                        len_q      <= frm_len;
                        attempts_q <= '0;
                        state_q    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!carrier) begin
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (collision) begin
                        state_q    <= ST_JAM;
                        jam_cnt_q  <= '0;
                        attempts_q <= attempts_q + ATT_W'(1);
                    end else if (last_byte_end) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                ST_JAM: begin
                    if (bit_tick) begin
                        if (jam_last) begin
                            jam_cnt_q <= '0;
                            if (limit_hit) begin
                                err_q   <= 1'b1;
                                state_q <= ST_IDLE;
                            end else if (draw == '0) begin
                                state_q <= ST_WAIT;
                            end else begin
                                state_q <= ST_BACKOFF;
                            end
                        end else begin
                            jam_cnt_q <= jam_cnt_q + JAM_W'(1);
                        end
                    end
                end
                ST_BACKOFF: begin
                    if (bo_expire) begin
                        state_q <= ST_WAIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the medium and the source handshake from the current phase.
    always_comb begin
        tx_en      = (state_q == ST_SEND) || (state_q == ST_JAM);
        jam        = state_q == ST_JAM;
        in_ready   = byte_end && byte_is_data;
        tx_data    = ((state_q == ST_SEND) && byte_is_data && in_valid) ? in_data : 8'h00;
        done       = done_q;
        excess_err = err_q;
    end

endmodule

// File: rtl/csma_tx_checker.sv
// Port-level temporal checks for the transmit access controller.
// Assumes it is bound to csma_tx_ctrl and sees its clock and reset.
module csma_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic carrier,
    input logic collision,
    input logic tx_en,
    input logic jam,
    input logic in_ready,
    input logic done,
    input logic excess_err
);

    a_r1_start_on_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(!carrier));

    a_r2_ready_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (tx_en && !jam));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_line_free: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tx_en);

    a_r5_collision_jams: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !jam && collision) |=> (jam && tx_en));

    a_r6_jam_drives: assert property (@(posedge clk) disable iff (!rst_n)
        jam |-> tx_en);

    a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        excess_err |-> (!tx_en && !done));

    a_r8_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
        excess_err |=> !excess_err);

endmodule

bind csma_tx_ctrl csma_tx_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .carrier    (carrier),
    .collision  (collision),
    .tx_en      (tx_en),
    .jam        (jam),
    .in_ready   (in_ready),
    .done       (done),
    .excess_err (excess_err)
);

// File: tb/test_csma_tx_ctrl.sv
// Self-checking bench: a behavioural per-cycle model compared every clock.
module test_csma_tx_ctrl;

    localparam int LEN_W = 11;
    localparam int MINB  = 64;
    localparam int JAMB  = 32;
    localparam int SLOT  = 16;
    localparam int LIM   = 6;
    localparam int MAXA  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic req = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic carrier = 1'b0;
    logic coll = 1'b0;
    logic in_valid = 1'b1;
    logic [7:0] in_data = 8'h80;
    logic in_ready, tx_en, jam, done, excess_err;
    logic [7:0] tx_data;

    always #4 clk = ~clk;

    csma_tx_ctrl #(
        .LEN_W(LEN_W), .MIN_BYTES(MINB), .JAM_BITS(JAMB), .SLOT_BITS(SLOT),
        .BACKOFF_LIMIT(LIM), .MAX_ATTEMPTS(MAXA)
    ) i_csma_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frm_req(req),
        .frm_len(len), .carrier(carrier), .collision(coll), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .tx_en(tx_en), .tx_data(tx_data),
        .jam(jam), .done(done), .excess_err(excess_err)
    );

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // model state: 0 idle, 1 wait, 2 send, 3 jam, 4 backoff
    int mst = 0, mlen = 0, natt = 0, bidx = 0, bitc = 0, jc = 0, bo = 0, ptr = 0;
    bit done_e = 0, err_e = 0;
    int colls_left = 0;
    bit forced = 0, noise = 0, after_drop = 0;

    function automatic logic [7:0] byte_of(int p);
        return 8'h80 | 8'(p & 127);
    endfunction

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic model_update();
        int total;
        done_e = 0;
        err_e  = 0;
        if (!rst_n) begin
            mst = 0; mlen = 0; natt = 0; bidx = 0; bitc = 0; jc = 0; bo = 0; ptr = 0;
            return;
        end
        total = (mlen < MINB) ? MINB : mlen;
        case (mst)
            0: if (req) begin mlen = int'(len); natt = 0; ptr = 0; mst = 1; end
            1: if (!carrier) begin mst = 2; bidx = 0; bitc = 0; end
            2: begin
                if (coll) begin
                    mst = 3; jc = 0; natt++; ptr = 0;
                    if (colls_left > 0) colls_left--;
                end else if (bit_tick) begin
                    if (bitc == 7) begin
                        bitc = 0;
                        if (bidx < mlen) ptr++;
                        if (bidx == total - 1) begin mst = 0; done_e = 1; end
                        else bidx++;
                    end else bitc++;
                end
            end
            3: if (bit_tick) begin
                if (jc == JAMB - 1) begin
                    if (natt == MAXA) begin err_e = 1; mst = 0; end
                    else begin mst = 4; bo = 0; end
                end else jc++;
            end
            4: if (bit_tick) bo++;
            default: mst = 0;
        endcase
    endtask

    task automatic drive();
        bit_tick = ~bit_tick;
        if (done_e || err_e) req = 1'b0;
        coll = forced || (colls_left > 0 && mst == 2 && bidx == 2 && bitc == 3) || (noise && mst == 3);
        in_data = byte_of(ptr);
        in_valid = 1'b1;
    endtask

    task automatic compare();
        int bound, e;
        bit pad;
        string t;
        if (mst == 4 && tx_en === 1'b1) begin
            e = (natt < LIM) ? natt : LIM;
            bound = (1 << e) - 1;
            t = after_drop ? "R11" : "R7";
            cmp(t, "backoff whole slots", bo % SLOT, 0);
            cmp(t, "backoff within range", (bo / SLOT) <= bound, 1);
            mst = 2; bidx = 0; bitc = 0; ptr = 0;
        end
        pad = (mst == 2) && (bidx >= mlen);
        if (!rst_n) t = "R10";
        else if (forced) t = "R9";
        else if (mst == 1) t = "R1";
        else if (mst == 3) t = "R5";
        else if (mst == 4) t = "R7";
        else t = "R2";
        cmp(t, "tx_en", tx_en, (mst == 2 || mst == 3));
        cmp(!rst_n ? "R10" : "R6", "jam", jam, (mst == 3));
        cmp(!rst_n ? "R10" : (pad ? "R3" : "R2"), "in_ready", in_ready,
            (mst == 2 && !coll && bit_tick && bitc == 7 && bidx < mlen));
        cmp(!rst_n ? "R10" : (pad ? "R3" : (mst == 3 ? "R5" : "R2")), "tx_data", tx_data,
            (mst == 2 && bidx < mlen) ? byte_of(ptr) : 8'h00);
        cmp(!rst_n ? "R10" : "R4", "done", done, done_e);
        cmp(!rst_n ? "R10" : "R8", "excess_err", excess_err, err_e);
    endtask

    task automatic step();
        @(posedge clk);
        cycles++;
        model_update();
        #1;
        drive();
        #3;
        compare();
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            finish_up();
        end
    endtask

    task automatic run_frame(int l, bit expect_err, string tag);
        bit seen_done = 0, seen_err = 0;
        int n = 0;
        req = 1'b1;
        len = LEN_W'(l);
        while (!seen_done && !seen_err && n < 60000) begin
            step();
            n++;
            if (done_e) seen_done = 1;
            if (err_e) seen_err = 1;
        end
        cmp(tag, "frame sent", seen_done, !expect_err);
        cmp(tag, "frame dropped", seen_err, expect_err);
        if (n >= 60000) begin
            fails++;
            $display("FAIL watchdog frame hung (%s)", tag);
            finish_up();
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step();           // R10: outputs checked under reset
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step();           // R10: quiet after reset

        run_frame(100, 0, "R2");                     // long frame, no padding, R4 done
        for (int i = 0; i < 5; i++) step();
        run_frame(5, 0, "R3");                       // short frame padded to 64

        carrier = 1'b1;                              // R1: defer while busy
        req = 1'b1; len = LEN_W'(70);
        for (int i = 0; i < 40; i++) step();
        carrier = 1'b0;
        run_frame(70, 0, "R1");

        forced = 1'b1;                               // R9: collision while idle
        for (int i = 0; i < 6; i++) step();
        forced = 1'b0;
        for (int i = 0; i < 2; i++) step();

        noise = 1'b1; colls_left = 2;                // R5, R6, R7, R9 during jam
        run_frame(64, 0, "R7");
        noise = 1'b0;
        for (int i = 0; i < 4; i++) step();

        colls_left = MAXA;                           // R8: every attempt collides
        run_frame(80, 1, "R8");
        for (int i = 0; i < 4; i++) step();

        after_drop = 1'b1; colls_left = 1;           // R11: count restarts
        run_frame(64, 0, "R11");
        for (int i = 0; i < 4; i++) step();
        finish_up();
    end

endmodule